// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns the two phase signals of an incremental encoder into a position count held in the system clock domain. Each phase goes through the same conditioning path. A flip-flop chain synchronizes it. An optional glitch filter then accepts a new level only once it has held for a programmable number of clocks. Last comes a polarity select that can invert the phase.

A mode input selects how the two conditioned phases are read. In count-and-direction mode, phase A is a step clock and phase B gives the direction. In phase mode, the pair is read as a two-bit Gray code and decoded at four counts per cycle. The counter runs between a lower bound and an upper bound, both set by input ports, and wraps at either end. The block reports the direction of the most recent step and the direction of the most recent wrap, and pulses a flag on each wrap.

Top module: `qdec_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` loads `initVal`, and `countDir`, `wrapDir` and `wrapPulse` are cleared. The first conditioned levels seen after reset are taken as a baseline and do not count.
- R2: With `cntDirMode`=1, `count` changes only on a 0-to-1 transition of conditioned phase A. Conditioned B=1 increments and B=0 decrements. Falling A edges and any B changes alone leave `count` unchanged.
- R3: With `cntDirMode`=0, the (A,B) sequence 00→10→11→01→00 (A leading) increments `count` by one on each transition.
- R4: With `cntDirMode`=0, the sequence 00→01→11→10→00 (B leading) decrements `count` by one on each transition.
- R5: With `cntDirMode`=0, a transition in which A and B both change in the same cycle leaves `count` and `countDir` unchanged.
- R6: `invA`/`invB`=1 inverts that phase after filtering. With `invA`=1 in count-and-direction mode, a falling pin edge on A counts and a rising pin edge on A does not.
- R7: With the filter enabled and length L>0, a new synchronized level is accepted only after it has been stable for 4·L+1 consecutive clocks. A pulse one clock shorter is ignored.
- R8: With the filter disabled, or with L=0, the synchronized level passes straight through, so a one-clock pulse is seen.
- R9: An increment from `count`==`modVal` loads `initVal`, raises `wrapPulse` for that one cycle, and sets `wrapDir` to 1.
- R10: A decrement from `count`==`initVal` loads `modVal`, raises `wrapPulse` for that one cycle, and clears `wrapDir` to 0.
- R11: `countDir` is 1 after an increment step and 0 after a decrement step. It holds its value between steps.
- R12: Outside reset, `count` changes only by +1, by −1, or in a cycle where `wrapPulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseAIn | input | 1 | Encoder phase A pin |
| phaseBIn | input | 1 | Encoder phase B pin |
| fltEnA | input | 1 | Glitch filter enable, phase A |
| fltEnB | input | 1 | Glitch filter enable, phase B |
| fltLenA | input | 4 | Filter length L for phase A (4·L+1 clocks) |
| fltLenB | input | 4 | Filter length L for phase B |
| invA | input | 1 | Invert phase A |
| invB | input | 1 | Invert phase B |
| cntDirMode | input | 1 | 1: count-and-direction, 0: x4 phase decoding |
| initVal | input | 16 | Lower count bound and up-wrap target |
| modVal | input | 16 | Upper count bound and down-wrap target |
| count | output | 16 | Position count |
| countDir | output | 1 | Direction of last step (1 = up) |
| wrapDir | output | 1 | Direction of last wrap (1 = up) |
| wrapPulse | output | 1 | One-cycle flag on each wrap |

## Verification
The hardest condition to reach from the ports is the exact acceptance edge of the glitch filter. The synchronizer delay makes the internal stability window hard to see from the pin. The stimulus drives phase A pulses held for a fixed number of clocks at L=1 and at L=15. Each length is tried at exactly 4·L+1 clocks and at one clock less, and the count shows which pulse passed. Both wrap directions are reached by stepping the count onto each bound on purpose. Simultaneous phase changes are driven by changing both pins in the same cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // Step request from the edge decoder to the position datapath.
  typedef struct packed {
    logic step;   // move the count this cycle
    logic up;     // 1: increment, 0: decrement
  } qdec_step_t;
endpackage

// File: rtl/qdec_phase_cond.sv
module qdec_phase_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pinIn,
  input  logic             fltEn,
  input  logic [LEN_W-1:0] fltLen,
  input  logic             invert,
  output logic             condOut
);
  localparam int RUN_W = LEN_W + 3;

  logic [SYNC_STAGES-1:0] chain;
  logic                   syncLvl;
  logic                   held;
  logic [RUN_W-1:0]       run;
  logic [RUN_W-1:0]       limit;
  logic                   bypass;
  logic                   filtLvl;

  // Synchronizer chain
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-2:0], pinIn};
  end
  assign syncLvl = chain[SYNC_STAGES-1];

  // Stability window: 4*L+1 clocks
  assign limit  = {1'b0, fltLen, 2'b00} + RUN_W'(1);
  assign bypass = !fltEn || (fltLen == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      run  <= '0;
    end else if (bypass) begin
      held <= syncLvl;
      run  <= '0;
    end else if (syncLvl == held) begin
      run <= '0;
    end else if (run == limit - RUN_W'(1)) begin
      held <= syncLvl;
      run  <= '0;
    end else begin
      run <= run + RUN_W'(1);
    end
  end

  assign filtLvl = bypass ? syncLvl : held;
  assign condOut = filtLvl ^ invert;
endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phaseA,
  input  logic       phaseB,
  input  logic       cntDirMode,
  output qdec_step_t strobe
);
  logic       primed;
  logic       prevA;
  logic       prevB;
  logic [1:0] posNew;
  logic [1:0] posOld;
  logic [1:0] delta;

  // Gray position: 00->0, 10->1, 11->2, 01->3
  function automatic logic [1:0] grayPos(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      prevA  <= 1'b0;
      prevB  <= 1'b0;
    end else begin
      primed <= 1'b1;
      prevA  <= phaseA;
      prevB  <= phaseB;
    end
  end

  assign posNew = grayPos(phaseA, phaseB);
  assign posOld = grayPos(prevA, prevB);
  assign delta  = posNew - posOld;

  always_comb begin
    strobe = '0;
    if (primed) begin
      if (cntDirMode) begin
        strobe.step = !prevA && phaseA;
        strobe.up   = phaseB;
      end else begin
        // delta 1: forward, 3: backward, 2: illegal double change
        strobe.step = (delta == 2'd1) || (delta == 2'd3);
        strobe.up   = (delta == 2'd1);
      end
    end
  end
endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  qdec_step_t       strobe,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] count,
  output logic             countDir,
  output logic             wrapDir,
  output logic             wrapPulse
);
  logic atTop;
  logic atBottom;

  assign atTop    = (count == modVal);
  assign atBottom = (count == initVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= initVal;
      countDir  <= 1'b0;
      wrapDir   <= 1'b0;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= 1'b0;
      if (strobe.step) begin
        countDir <= strobe.up;
        if (strobe.up) begin
          if (atTop) begin
            count     <= initVal;
            wrapDir   <= 1'b1;
            wrapPulse <= 1'b1;
          end else begin
            count <= count + CNT_W'(1);
          end
        end else begin
          if (atBottom) begin
            count     <= modVal;
            wrapDir   <= 1'b0;
            wrapPulse <= 1'b1;
          end else begin
            count <= count - CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phaseAIn,
  input  logic             phaseBIn,
  input  logic             fltEnA,
  input  logic             fltEnB,
  input  logic [LEN_W-1:0] fltLenA,
  input  logic [LEN_W-1:0] fltLenB,
  input  logic             invA,
  input  logic             invB,
  input  logic             cntDirMode,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] count,
  output logic             countDir,
  output logic             wrapDir,
  output logic             wrapPulse
);
  localparam int NPH = 2;

  logic [NPH-1:0]            pins;
  logic [NPH-1:0]            enables;
  logic [NPH-1:0]            inverts;
  logic [NPH-1:0][LEN_W-1:0] lengths;
  logic [NPH-1:0]            cond;
  qdec_step_t                strobe;

  assign pins    = {phaseBIn, phaseAIn};
  assign enables = {fltEnB, fltEnA};
  assign inverts = {invB, invA};
  assign lengths = {fltLenB, fltLenA};

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    qdec_phase_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .LEN_W      (LEN_W)
    ) u_cond (
      .clk    (clk),
      .rst    (rst),
      .pinIn  (pins[p]),
      .fltEn  (enables[p]),
      .fltLen (lengths[p]),
      .invert (inverts[p]),
      .condOut(cond[p])
    );
  end

  qdec_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .phaseA    (cond[0]),
    .phaseB    (cond[1]),
    .cntDirMode(cntDirMode),
    .strobe    (strobe)
  );

  qdec_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .initVal  (initVal),
    .modVal   (modVal),
    .count    (count),
    .countDir (countDir),
    .wrapDir  (wrapDir),
    .wrapPulse(wrapPulse)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] initVal,
  input logic [CNT_W-1:0] modVal,
  input logic [CNT_W-1:0] count,
  input logic             countDir,
  input logic             wrapDir,
  input logic             wrapPulse
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == $past(initVal) && !countDir && !wrapDir && !wrapPulse));

  // R12
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      (count == CNT_W'($past(count) + CNT_W'(1)) ||
       count == CNT_W'($past(count) - CNT_W'(1)) || wrapPulse));

  // R9
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (wrapPulse && wrapDir) |-> (count == initVal));

  // R10
  wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (wrapPulse && !wrapDir) |-> (count == modVal));

  // R9
  wrap_dir_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wrapDir) |-> wrapPulse);
endmodule

bind qdec_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .initVal  (initVal),
  .modVal   (modVal),
  .count    (count),
  .countDir (countDir),
  .wrapDir  (wrapDir),
  .wrapPulse(wrapPulse)
);

// File: tb/qdec_counter_test.sv
module qdec_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phaseAIn = 1'b0, phaseBIn = 1'b0;
  logic        fltEnA = 1'b0, fltEnB = 1'b0;
  logic [3:0]  fltLenA = '0, fltLenB = '0;
  logic        invA = 1'b0, invB = 1'b0;
  logic        cntDirMode = 1'b1;
  logic [15:0] initVal = 16'd10, modVal = 16'd20;
  logic [15:0] count;
  logic        countDir, wrapDir, wrapPulse;

  typedef struct {
    int    cnt;
    bit    dir;
    bit    wdir;
    int    wraps;
    string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  int wrapsSeen = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  qdec_counter uut (
    .clk(clk), .rst(rst), .phaseAIn(phaseAIn), .phaseBIn(phaseBIn),
    .fltEnA(fltEnA), .fltEnB(fltEnB), .fltLenA(fltLenA), .fltLenB(fltLenB),
    .invA(invA), .invB(invB), .cntDirMode(cntDirMode),
    .initVal(initVal), .modVal(modVal),
    .count(count), .countDir(countDir), .wrapDir(wrapDir), .wrapPulse(wrapPulse)
  );

  always @(negedge clk) if (!rst && wrapPulse) wrapsSeen++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input int c, input bit d, input bit w, input int wr, input string tag);
    item_t it;
    it.cnt = c; it.dir = d; it.wdir = w; it.wraps = wr; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(4);
  endtask

  task automatic setAB(input bit a, input bit b, input int settle);
    phaseAIn = a;
    phaseBIn = b;
    tick(settle);
  endtask

  task automatic pulseA(input int width, input int settle);
    phaseAIn = 1'b1;
    tick(width);
    phaseAIn = 1'b0;
    tick(settle);
  endtask

  // Monitor: compares each queued expectation against the outputs
  initial begin
    forever begin
      wait (expQ.size() > 0);
      @(negedge clk);
      begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (count != it.cnt[15:0] || countDir != it.dir || wrapDir != it.wdir ||
            wrapsSeen != it.wraps) begin
          errors++;
          $display("FAIL %s: actual cnt=%0d dir=%0b wdir=%0b wraps=%0d expected cnt=%0d dir=%0b wdir=%0b wraps=%0d",
                   it.tag, count, countDir, wrapDir, wrapsSeen,
                   it.cnt, it.dir, it.wdir, it.wraps);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Count-and-direction mode
    cntDirMode = 1'b1;
    doReset();
    expectNow(10, 0, 0, 0, "R1 reset state");
    setAB(0, 1, 4);
    setAB(1, 1, 4);
    expectNow(11, 1, 0, 0, "R2 rising A with B=1 increments, R11");
    setAB(0, 1, 4);
    expectNow(11, 1, 0, 0, "R2 falling A ignored");
    setAB(0, 0, 4);
    expectNow(11, 1, 0, 0, "R2 B change alone ignored");
    setAB(1, 0, 4);
    expectNow(10, 0, 0, 0, "R2 rising A with B=0 decrements, R11");
    setAB(0, 0, 4);
    setAB(1, 0, 4);
    expectNow(20, 0, 0, 1, "R10 down wrap loads upper bound");
    setAB(0, 0, 4);
    setAB(0, 1, 4);
    setAB(1, 1, 4);
    expectNow(10, 1, 1, 2, "R9 up wrap loads lower bound");

    // Phase mode
    setAB(0, 0, 4);
    cntDirMode = 1'b0;
    doReset();
    expectNow(10, 0, 0, 2, "R1 reset clears flags");
    setAB(1, 0, 4); expectNow(11, 1, 0, 2, "R3 00->10");
    setAB(1, 1, 4); expectNow(12, 1, 0, 2, "R3 10->11");
    setAB(0, 1, 4); expectNow(13, 1, 0, 2, "R3 11->01");
    setAB(0, 0, 4); expectNow(14, 1, 0, 2, "R3 01->00");
    setAB(0, 1, 4); expectNow(13, 0, 0, 2, "R4 00->01");
    setAB(1, 1, 4); expectNow(12, 0, 0, 2, "R4 01->11");
    setAB(1, 0, 4); expectNow(11, 0, 0, 2, "R4 11->10");
    setAB(0, 0, 4); expectNow(10, 0, 0, 2, "R4 10->00");
    setAB(1, 1, 4); expectNow(10, 0, 0, 2, "R5 00->11 illegal");
    setAB(0, 0, 4); expectNow(10, 0, 0, 2, "R5 11->00 illegal");
    setAB(1, 0, 4); expectNow(11, 1, 0, 2, "R3 00->10 before illegal");
    setAB(0, 1, 4); expectNow(11, 1, 0, 2, "R5 10->01 illegal");

    // Polarity
    setAB(0, 1, 4);
    cntDirMode = 1'b1;
    invA = 1'b1;
    doReset();
    expectNow(10, 0, 0, 2, "R6 baseline after reset");
    setAB(1, 1, 4);
    expectNow(10, 0, 0, 2, "R6 inverted rising pin not counted");
    setAB(0, 1, 4);
    expectNow(11, 1, 0, 2, "R6 inverted falling pin counted");

    // Filter
    invA = 1'b0;
    fltEnA = 1'b1;
    fltLenA = 4'd1;
    doReset();
    tick(10);
    expectNow(10, 0, 0, 2, "R7 reset with filter");
    pulseA(4, 12);
    expectNow(10, 0, 0, 2, "R7 pulse of 4 clocks rejected at L=1");
    pulseA(5, 12);
    expectNow(11, 1, 0, 2, "R7 pulse of 5 clocks accepted at L=1");
    fltLenA = 4'd15;
    tick(4);
    pulseA(60, 70);
    expectNow(11, 1, 0, 2, "R7 pulse of 60 clocks rejected at L=15");
    pulseA(61, 70);
    expectNow(12, 1, 0, 2, "R7 pulse of 61 clocks accepted at L=15");
    fltLenA = 4'd0;
    tick(4);
    pulseA(1, 6);
    expectNow(13, 1, 0, 2, "R8 length zero passes one-clock pulse");
    fltEnA = 1'b0;
    fltLenA = 4'd15;
    tick(4);
    pulseA(1, 6);
    expectNow(14, 1, 0, 2, "R8 filter disabled passes one-clock pulse");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule